// File: doc/BRIEF.md
# Dual-Channel Slicer Activity Watchdog

This block watches two sliced serial bit streams and reports a single slicer failure status when a stream it is watching stops toggling. Channel 0 watches the main sliced data stream. Channel 1 watches the sliced digital voice-orderwire stream. Each channel behaves as a retriggerable one-shot. Every transition on its input, rising or falling, keeps the channel healthy for a fixed number of clock cycles. If the input stays quiet for that whole window, the channel drops back to its failed state.

An operating-mode input selects digital or analog orderwire operation. In analog operation no digital voice stream exists, so channel 1 is masked and cannot raise the status. Channel 0 contributes in both modes. The status is the OR of the failure terms of the unmasked channels. An active-low indicator drive is the inverse of the status, so the lamp stays dark while the streams are healthy. Both inputs are asynchronous and pass through a two-flop synchronizer. After reset both channels start out failed.

Top module: `slicer_activity_watchdog`

## Requirements
- R1: While `rst` is sampled high, and after it until activity is seen, `slicer_fail` is 1 and `fail_led_n` is 0.
- R2: Activity on an input is any change of its level, in either direction, between two consecutive rising clock edges. A change sampled at edge a, with a at least two edges after the last edge that had `rst` high, is the first change that can act on the output, at edge a+3.
- R3: After the last change on a channel sampled at edge a, that channel counts as healthy in the status computed at edges a+3 through a+TIMEOUT_CYCLES+2. From edge a+TIMEOUT_CYCLES+3 it counts as failed.
- R4: Every change restarts the full healthy window of its channel, including a change that arrives in the last cycle of a running window.
- R5: A failed data channel (channel 0) sets `slicer_fail` whatever the value of `mode_digital`.
- R6: With `mode_digital`=0 (analog), the voice channel (channel 1) has no effect on `slicer_fail`. With `mode_digital`=1 (digital), a failed voice channel sets `slicer_fail`.
- R7: A value of `mode_digital` sampled at edge m governs the status registered at edge m. A mode change does not restart or clear either channel's window.
- R8: `slicer_fail` registered at an edge is the OR of the failure terms of the unmasked channels. It is 0 when both channels are healthy in digital mode.
- R9: `fail_led_n` is always the inverse of `slicer_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 1 | Sliced main data stream, asynchronous |
| voice_in | input | 1 | Sliced digital voice-orderwire stream, asynchronous |
| mode_digital | input | 1 | 1 = digital orderwire mode, 0 = analog orderwire mode |
| slicer_fail | output | 1 | Registered combined fail status, 1 = fail |
| fail_led_n | output | 1 | Registered indicator drive, 0 = lamp on |

## Verification
Two events can land in the same cycle. A new input change can reload a channel in the very cycle its window would otherwise expire. A mode flip can also coincide with the voice channel timing out. The bench sweeps the gap between data changes from one cycle up to past the timeout, so the reload-at-expiry cycle is reached exactly. It also toggles `mode_digital` cycle by cycle around a voice expiry, and later at random over long random traffic. Each cycle it compares both outputs against a model that computes, from the recorded sample history alone, each channel's window and the mode sampled at that edge.

// File: rtl/saw_pkg.sv
package saw_pkg;
  typedef enum logic {
    OW_ANALOG  = 1'b0,
    OW_DIGITAL = 1'b1
  } ow_mode_e;

  localparam int NUM_CH   = 2;
  localparam int CH_DATA  = 0;
  localparam int CH_VOICE = 1;
endpackage

// File: rtl/saw_edge_sync.sv
module saw_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic [STAGES:0]   fill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      fill_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
      fill_q <= {fill_q[STAGES-1:0], 1'b1};
    end
  end

  // only compare once the delay line holds real samples
  assign edge_o = fill_q[STAGES] & (sync_q[STAGES-1] ^ prev_q);
endmodule

// File: rtl/saw_activity_timer.sv
module saw_activity_timer #(
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic alive
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (kick)
      cnt_q <= RELOAD;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign alive = (cnt_q != '0);
endmodule

// File: rtl/saw_fail_combine.sv
module saw_fail_combine #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] alive,
  input  logic [NUM_CH-1:0] enable,
  output logic              fail_o,
  output logic              led_n_o
);
  logic fail_d;

  assign fail_d = |(~alive & enable);

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_o  <= 1'b1;
      led_n_o <= 1'b0;
    end else begin
      fail_o  <= fail_d;
      led_n_o <= ~fail_d;
    end
  end
endmodule

// File: rtl/slicer_activity_watchdog.sv
module slicer_activity_watchdog
  import saw_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic data_in,
  input  logic voice_in,
  input  logic mode_digital,
  output logic slicer_fail,
  output logic fail_led_n
);
  ow_mode_e          mode_e;
  logic [NUM_CH-1:0] ch_in;
  logic [NUM_CH-1:0] ch_kick;
  logic [NUM_CH-1:0] ch_alive;
  logic [NUM_CH-1:0] ch_enable;

  assign mode_e          = ow_mode_e'(mode_digital);
  assign ch_in[CH_DATA]  = data_in;
  assign ch_in[CH_VOICE] = voice_in;

  // data channel always counts; voice only exists in digital operation
  assign ch_enable[CH_DATA]  = 1'b1;
  assign ch_enable[CH_VOICE] = (mode_e == OW_DIGITAL);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    saw_edge_sync #(
      .STAGES(SYNC_STAGES)
    ) u_sync (
      .clk   (clk),
      .rst   (rst),
      .din   (ch_in[c]),
      .edge_o(ch_kick[c])
    );

    saw_activity_timer #(
      .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) u_timer (
      .clk  (clk),
      .rst  (rst),
      .kick (ch_kick[c]),
      .alive(ch_alive[c])
    );
  end

  saw_fail_combine #(
    .NUM_CH(NUM_CH)
  ) u_comb (
    .clk    (clk),
    .rst    (rst),
    .alive  (ch_alive),
    .enable (ch_enable),
    .fail_o (slicer_fail),
    .led_n_o(fail_led_n)
  );
endmodule

// File: rtl/saw_checker.sv
module saw_checker (
  input logic       clk,
  input logic       rst,
  input logic       mode_digital,
  input logic       slicer_fail,
  input logic       fail_led_n,
  input logic [1:0] alive,
  input logic [1:0] kick
);
  AST_RESET_FAIL: assert property (@(posedge clk) rst |=> (slicer_fail && !fail_led_n)); // R1
  AST_KICK_ALIVE: assert property (@(posedge clk) disable iff (rst) kick[0] |=> alive[0]); // R4
  AST_VKICK_ALIVE: assert property (@(posedge clk) disable iff (rst) kick[1] |=> alive[1]); // R4
  AST_DATA_DEAD: assert property (@(posedge clk) disable iff (rst) !alive[0] |=> slicer_fail); // R5
  AST_ANALOG_MASK: assert property (@(posedge clk) disable iff (rst) (!mode_digital && alive[0]) |=> !slicer_fail); // R6
  AST_VOICE_DEAD: assert property (@(posedge clk) disable iff (rst) (mode_digital && !alive[1]) |=> slicer_fail); // R6
  AST_BOTH_OK: assert property (@(posedge clk) disable iff (rst) (alive[0] && alive[1]) |=> !slicer_fail); // R8
  AST_LED_INV: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (fail_led_n == !slicer_fail)); // R9
endmodule

bind slicer_activity_watchdog saw_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_digital(mode_digital),
  .slicer_fail (slicer_fail),
  .fail_led_n  (fail_led_n),
  .alive       (ch_alive),
  .kick        (ch_kick)
);

// File: tb/slicer_activity_watchdog_test.sv
module slicer_activity_watchdog_test;
  localparam int T    = 8;
  localparam int NMAX = 16384;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic data_in = 1'b0;
  logic voice_in = 1'b0;
  logic mode_digital = 1'b1;
  logic slicer_fail;
  logic fail_led_n;

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  bit rs [NMAX];
  bit md [NMAX];
  bit td [NMAX];
  bit tv [NMAX];
  int cyc = 0;
  int lastrst = 0;
  logic pd = 1'b0;
  logic pv = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slicer_activity_watchdog #(.TIMEOUT_CYCLES(T), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .data_in(data_in), .voice_in(voice_in),
    .mode_digital(mode_digital), .slicer_fail(slicer_fail), .fail_led_n(fail_led_n)
  );

  // record what every edge samples
  always @(posedge clk) begin
    if (cyc < NMAX - 1) begin
      cyc = cyc + 1;
      rs[cyc] = rst;
      md[cyc] = mode_digital;
      td[cyc] = (data_in !== pd);
      tv[cyc] = (voice_in !== pv);
      if (rst) lastrst = cyc;
    end
    pd = data_in;
    pv = voice_in;
  end

  function automatic bit healthy(input bit ch, input int m);
    int lo;
    lo = m - T - 2;
    if (lo < lastrst + 2) lo = lastrst + 2;
    for (int a = m - 3; a >= lo; a--)
      if (ch ? tv[a] : td[a]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit expect_fail(input int m);
    if (rs[m]) return 1'b1;
    return !healthy(1'b0, m) || (md[m] && !healthy(1'b1, m));
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cycle %0d actual=%b expected=%b", req, cyc, act, exp);
    end
  endtask

  // per-cycle model comparison on both outputs
  always @(negedge clk) begin
    if (cyc >= 1 && !done) begin
      chk(slicer_fail, expect_fail(cyc), tag);
      chk(fail_led_n, !expect_fail(cyc), "R9");
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tag = "R1";
    tick(12);
    chk(slicer_fail, 1'b1, "R1");
    chk(fail_led_n, 1'b0, "R1");

    // data alive only, digital mode: voice dead keeps fail
    tag = "R6";
    for (int i = 0; i < 10; i++) begin data_in = ~data_in; tick(3); end
    chk(slicer_fail, 1'b1, "R6");

    // both alive
    tag = "R8";
    for (int i = 0; i < 15; i++) begin data_in = ~data_in; voice_in = ~voice_in; tick(2); end
    chk(slicer_fail, 1'b0, "R8");

    // both stop: timeout
    tag = "R3";
    tick(T + 6);
    chk(slicer_fail, 1'b1, "R3");

    // gap sweep on data with voice busy, reload at expiry
    tag = "R4";
    for (int g = 1; g <= T + 3; g++) begin
      for (int r = 0; r < 3; r++) begin
        data_in = ~data_in;
        for (int k = 0; k < g; k++) begin voice_in = ~voice_in; tick(1); end
      end
    end

    // analog mode: voice ignored, data still counts
    tag = "R6";
    mode_digital = 1'b0;
    for (int i = 0; i < 12; i++) begin data_in = ~data_in; tick(4); end
    chk(slicer_fail, 1'b0, "R6");
    tag = "R5";
    tick(T + 6);
    chk(slicer_fail, 1'b1, "R5");

    // mode flips around a voice expiry, data kept busy
    tag = "R7";
    for (int off = 0; off < T + 4; off++) begin
      mode_digital = 1'b1;
      voice_in = ~voice_in;
      for (int k = 0; k < T + 6; k++) begin
        data_in = ~data_in;
        mode_digital = (k == off) ? 1'b0 : ((k > off + 2) ? ~mode_digital : 1'b1);
        tick(1);
      end
    end

    // long random traffic sweep
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) < 2) data_in = ~data_in;
      if ($urandom_range(0, 13) < 2) voice_in = ~voice_in;
      if ($urandom_range(0, 39) == 0) mode_digital = ~mode_digital;
      tick(1);
    end

    // reset in the middle of activity
    tag = "R1";
    mode_digital = 1'b1;
    rst = 1'b1;
    for (int i = 0; i < 4; i++) begin data_in = ~data_in; voice_in = ~voice_in; tick(1); end
    rst = 1'b0;
    tick(3);
    chk(slicer_fail, 1'b1, "R1");
    tick(T + 4);
    finish_run();
  end
endmodule